// File: doc/BRIEF.md
# Configuration Request Packet Generator

This block turns one byte-granular configuration access at a time into a configuration request packet for a root port transmit path. A request names a target bus, a device/function number, a byte offset, an access size of one, two or four bytes, a direction and, for writes, the data. The block derives the byte enables, formats a fixed three-dword request header, aligns the write data to its byte lanes and sends header and payload as a short run of 64-bit beats. Each beat carries a two-bit control field with a start marker and an end marker.

The beat layout depends on the quadword alignment of the offset. A write whose offset is a multiple of eight takes three beats, with the data alone in the last one. Every other write, and every read, takes two beats, with the data (zero for a read) in the upper lane beside the third header dword. A local root bus number decides between type 0 requests (target on the root bus) and type 1 requests (anything else). A write to the primary bus number register of the root port updates that local copy, so later requests are classified against the new value.

Requests enter through a valid/ready handshake and beats leave through a valid/ready handshake. The block takes a new request only when the previous packet has fully left.

Top module: `cfg_req_gen`

## Requirements
- R1: After reset tx_valid is 0, req_ready is 1 and root_bus equals the ROOT_BUS_RST parameter (default 0x00).
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1; tx_valid is 1 from the next cycle on, and req_ready stays 0 until the edge on which the end beat is accepted, after which req_ready returns to 1.
- R3: While tx_valid is 1 and tx_ready is 0, tx_data and tx_ctl hold their values; a beat counts as sent only on an edge with tx_valid and tx_ready both 1.
- R4: The byte-enable field is 0x01 shifted left by offset[1:0] for req_size code 0 (one byte), 0x03 shifted left by offset[1:0] and cut to 8 bits for code 1 (two bytes), and 0x0F for codes 2 and 3 (four bytes).
- R5: Header dword 0 holds the format/type code in bits 31:24, the value 1 in bits 9:0 and zero elsewhere; codes are 0x04 type 0 read, 0x44 type 0 write, 0x05 type 1 read, 0x45 type 1 write.
- R6: Header dword 1 holds the root bus number in bits 31:24, zero in bits 23:16, the tag in bits 15:8 (0x1D for a read, 0x10 for a write) and the byte enables in bits 7:0.
- R7: Header dword 2 holds the target bus in bits 31:24, the device/function in bits 23:16 and the offset zero-extended to 16 bits with bits 1:0 cleared in bits 15:0.
- R8: A request is type 0 when its target bus equals the current root bus number and type 1 otherwise.
- R9: Write data is masked to the access size (low 8, 16 or 32 bits) and shifted left by 8*offset[1:0], keeping the low 32 bits; read data lanes are zero.
- R10: In each beat bits 31:0 carry the earlier dword and bits 63:32 the later one; tx_ctl bit 0 marks the first beat and bit 1 the last. Beat 1 is {dword1, dword0} with control 01. A write with offset[2:0]==0 then sends {0, dword2} with control 00 and {0, data} with control 10; any other request sends {data, dword2} with control 10.
- R11: When the end beat of a write is accepted whose target bus equals the root bus number and whose offset with bits 1:0 cleared is 0x18, root_bus takes bits 7:0 of the shifted write data from the next cycle; nothing else changes root_bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function number |
| req_off | input | OFF_W (12) | Byte offset in configuration space |
| req_size | input | 2 | Access size code: 0 one byte, 1 two bytes, 2 or 3 four bytes |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | 32 | Write value, right-aligned |
| tx_valid | output | 1 | Beat present |
| tx_ready | input | 1 | Downstream takes the beat |
| tx_data | output | 64 | Beat payload, earlier dword in bits 31:0 |
| tx_ctl | output | 2 | Bit 0 start marker, bit 1 end marker |
| root_bus | output | 8 | Current local root bus number |

## Verification
The hardest case to reach from the ports is a root bus update immediately followed by requests that depend on it: the update lands only when the end beat of a qualifying write is taken, and the very next request must change between type 0 and type 1 and carry the new number in its requester field. The stimulus runs a directed sequence that rewrites the primary bus register, then targets both the new and the old root bus, writes the register again on a bus that is no longer the root, and finally hits it with an unaligned byte write whose shifted low byte is zero. Around this, random requests of every size and alignment run while the transmit ready is held low for random stretches, so every beat type is stalled at least once.

// File: rtl/cfg_req_pkg.sv
package cfg_req_pkg;

  localparam int DW_W   = 32;
  localparam int BEAT_W = 2 * DW_W;
  localparam int BYTE_W = 8;
  localparam int LANES  = DW_W / BYTE_W;
  localparam int FOFF_W = 16;

  localparam logic [7:0] FMT_RD_T0 = 8'h04;
  localparam logic [7:0] FMT_WR_T0 = 8'h44;
  localparam logic [7:0] FMT_RD_T1 = 8'h05;
  localparam logic [7:0] FMT_WR_T1 = 8'h45;

  localparam logic [7:0] TAG_RD = 8'h1D;
  localparam logic [7:0] TAG_WR = 8'h10;

  localparam logic [9:0]        LEN_ONE      = 10'd1;
  localparam logic [FOFF_W-1:0] PRI_BUS_OFF  = 16'h0018;

  localparam logic [1:0] CTL_NONE  = 2'b00;
  localparam logic [1:0] CTL_START = 2'b01;
  localparam logic [1:0] CTL_END   = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HEAD = 2'd1,
    ST_ADDR = 2'd2,
    ST_DATA = 2'd3
  } beat_st_e;

  typedef struct packed {
    logic [7:0]        bus;
    logic [7:0]        devfn;
    logic [FOFF_W-1:0] off;
    logic [1:0]        size;
    logic              wr;
    logic [DW_W-1:0]   wdata;
  } cfg_req_t;

endpackage

// File: rtl/cfg_req_hdr.sv
module cfg_req_hdr
  import cfg_req_pkg::*;
(
  input  cfg_req_t        req,
  input  logic [7:0]      root_bus,
  output logic [DW_W-1:0] dw0,
  output logic [DW_W-1:0] dw1,
  output logic [DW_W-1:0] dw2,
  output logic [DW_W-1:0] data_lane,
  output logic            qw_aligned_wr,
  output logic            hits_pri_bus
);

  logic [1:0]        byte_sel;
  logic [7:0]        be_base;
  logic [7:0]        be;
  logic [LANES-1:0]  lane_keep;
  logic [DW_W-1:0]   masked;
  logic [DW_W-1:0]   shifted;
  logic              type0;
  logic [7:0]        fmt;
  logic [FOFF_W-1:0] off_dw;

  assign byte_sel = req.off[1:0];
  assign off_dw   = {req.off[FOFF_W-1:2], 2'b00};
  assign type0    = (req.bus == root_bus);

  always_comb begin
    case (req.size)
      2'd0:    be_base = 8'h01;
      2'd1:    be_base = 8'h03;
      default: be_base = 8'h0F;
    endcase
    if (req.size[1]) be = be_base;
    else             be = 8'(be_base << byte_sel);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i == 0) begin : g_first
      assign lane_keep[i] = 1'b1;
    end else if (i == 1) begin : g_second
      assign lane_keep[i] = (req.size != 2'd0);
    end else begin : g_upper
      assign lane_keep[i] = req.size[1];
    end
    assign masked[i*BYTE_W +: BYTE_W] =
      lane_keep[i] ? req.wdata[i*BYTE_W +: BYTE_W] : '0;
  end

  assign shifted = DW_W'(masked << {byte_sel, 3'b000});

  always_comb begin
    case ({req.wr, type0})
      2'b01:   fmt = FMT_RD_T0;
      2'b00:   fmt = FMT_RD_T1;
      2'b11:   fmt = FMT_WR_T0;
      default: fmt = FMT_WR_T1;
    endcase
  end

  assign dw0 = {fmt, 14'd0, LEN_ONE};
  assign dw1 = {root_bus, 8'h00, (req.wr ? TAG_WR : TAG_RD), be};
  assign dw2 = {req.bus, req.devfn, off_dw};

  assign data_lane     = req.wr ? shifted : '0;
  assign qw_aligned_wr = req.wr && (req.off[2:0] == 3'b000);
  assign hits_pri_bus  = req.wr && type0 && (off_dw == PRI_BUS_OFF);

endmodule

// File: rtl/cfg_req_seq.sv
module cfg_req_seq
  import cfg_req_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     three_beat,
  input  logic     tx_ready,
  output beat_st_e state,
  output logic     busy,
  output logic     last_taken
);

  beat_st_e state_q;
  beat_st_e state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start)    state_d = ST_HEAD;
      ST_HEAD: if (tx_ready) state_d = ST_ADDR;
      ST_ADDR: if (tx_ready) state_d = three_beat ? ST_DATA : ST_IDLE;
      ST_DATA: if (tx_ready) state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state      = state_q;
  assign busy       = (state_q != ST_IDLE);
  assign last_taken = tx_ready &&
                      (((state_q == ST_ADDR) && !three_beat) || (state_q == ST_DATA));

endmodule

// File: rtl/cfg_req_rootbus.sv
module cfg_req_rootbus #(
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_en,
  input  logic [7:0] upd_val,
  output logic [7:0] root_bus
);

  logic [7:0] bus_q;
  logic [7:0] bus_d;

  always_comb begin
    bus_d = bus_q;
    if (upd_en) bus_d = upd_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_q <= RST_VAL;
    else        bus_q <= bus_d;
  end

  assign root_bus = bus_q;

endmodule

// File: rtl/cfg_req_gen.sv
module cfg_req_gen
  import cfg_req_pkg::*;
#(
  parameter int         OFF_W        = 12,
  parameter logic [7:0] ROOT_BUS_RST = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_bus,
  input  logic [7:0]        req_devfn,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [DW_W-1:0]   req_wdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BEAT_W-1:0] tx_data,
  output logic [1:0]        tx_ctl,
  output logic [7:0]        root_bus
);

  localparam int OFF_PAD = FOFF_W - OFF_W;

  cfg_req_t        cur_q;
  cfg_req_t        cur_d;
  cfg_req_t        in_req;
  beat_st_e        state;
  logic            busy;
  logic            last_taken;
  logic            accept;
  logic [DW_W-1:0] dw0;
  logic [DW_W-1:0] dw1;
  logic [DW_W-1:0] dw2;
  logic [DW_W-1:0] data_lane;
  logic            three_beat;
  logic            hits_pri_bus;

  assign in_req = '{bus:   req_bus,
                    devfn: req_devfn,
                    off:   {{OFF_PAD{1'b0}}, req_off},
                    size:  req_size,
                    wr:    req_write,
                    wdata: req_wdata};

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;

  always_comb begin
    cur_d = cur_q;
    if (accept) cur_d = in_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= cur_d;
  end

  cfg_req_hdr u_hdr (
    .req           (cur_q),
    .root_bus      (root_bus),
    .dw0           (dw0),
    .dw1           (dw1),
    .dw2           (dw2),
    .data_lane     (data_lane),
    .qw_aligned_wr (three_beat),
    .hits_pri_bus  (hits_pri_bus)
  );

  cfg_req_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .three_beat (three_beat),
    .tx_ready   (tx_ready),
    .state      (state),
    .busy       (busy),
    .last_taken (last_taken)
  );

  cfg_req_rootbus #(
    .RST_VAL (ROOT_BUS_RST)
  ) u_root (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (last_taken && hits_pri_bus),
    .upd_val  (data_lane[7:0]),
    .root_bus (root_bus)
  );

  always_comb begin
    tx_data = '0;
    tx_ctl  = CTL_NONE;
    case (state)
      ST_HEAD: begin
        tx_data = {dw1, dw0};
        tx_ctl  = CTL_START;
      end
      ST_ADDR: begin
        if (three_beat) begin
          tx_data = {{DW_W{1'b0}}, dw2};
          tx_ctl  = CTL_NONE;
        end else begin
          tx_data = {data_lane, dw2};
          tx_ctl  = CTL_END;
        end
      end
      ST_DATA: begin
        tx_data = {{DW_W{1'b0}}, data_lane};
        tx_ctl  = CTL_END;
      end
      default: begin
        tx_data = '0;
        tx_ctl  = CTL_NONE;
      end
    endcase
  end

  assign tx_valid = busy;

endmodule

// File: rtl/cfg_req_gen_chk.sv
module cfg_req_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [63:0] tx_data,
  input logic [1:0]  tx_ctl,
  input logic [7:0]  root_bus
);

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_ctl)); // R3

  AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> tx_valid && (tx_ctl == 2'b01)); // R2

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !req_ready); // R2

  AST_END_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_ctl[1] |=> !tx_valid && req_ready); // R10

  AST_CTL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_ctl != 2'b11)); // R10

  AST_LEN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && (tx_ctl == 2'b01) |-> (tx_data[23:0] == 24'd1)); // R5

  AST_ROOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && tx_ready && tx_ctl[1]) |=> $stable(root_bus)); // R11

endmodule

bind cfg_req_gen cfg_req_gen_chk chk_i (.*);

// File: tb/cfg_req_gen_tb_top.sv
module cfg_req_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [7:0]  req_bus;
  logic [7:0]  req_devfn;
  logic [11:0] req_off;
  logic [1:0]  req_size;
  logic        req_write;
  logic [31:0] req_wdata;
  logic        tx_valid;
  logic        tx_ready;
  logic [63:0] tx_data;
  logic [1:0]  tx_ctl;
  logic [7:0]  root_bus;

  always #5 clk = ~clk;

  cfg_req_gen dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_bus   (req_bus),
    .req_devfn (req_devfn),
    .req_off   (req_off),
    .req_size  (req_size),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_ctl    (tx_ctl),
    .root_bus  (root_bus)
  );

  typedef struct {
    int          bus;
    int          devfn;
    int          off;
    int          size;
    int          wr;
    int unsigned wd;
  } rq_t;

  int          n_chk = 0;
  int          n_bad = 0;
  int          model_root = 0;
  rq_t         pend[$];
  logic [63:0] q_data[$];
  logic [1:0]  q_ctl[$];
  int          q_newroot[$];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void add_req(int bus, int devfn, int off, int size, int wr, int unsigned wd);
    rq_t r;
    r.bus = bus; r.devfn = devfn; r.off = off; r.size = size; r.wr = wr; r.wd = wd;
    pend.push_back(r);
  endfunction

  // Reference: expected beats of one request, from the requirement text.
  function automatic void build(rq_t r);
    int          o   = r.off % 4;
    int          be;
    longint      msk;
    logic [31:0] dat;
    int          fmt;
    int          tag;
    logic [31:0] d0, d1, d2;
    bit          t0  = (r.bus == model_root);
    case (r.size)
      0:       begin be = (1 << o) % 256; msk = 64'hFF;       end
      1:       begin be = (3 << o) % 256; msk = 64'hFFFF;     end
      default: begin be = 15;             msk = 64'hFFFFFFFF; end
    endcase
    dat = r.wr ? 32'((longint'(r.wd) & msk) << (8 * o)) : 32'h0;
    fmt = (r.wr ? 'h44 : 'h04) + (t0 ? 0 : 1);
    tag = r.wr ? 'h10 : 'h1D;
    d0  = 32'(fmt * (1 << 24) + 1);
    d1  = 32'(model_root * (1 << 24) + tag * 256 + be);
    d2  = 32'(r.bus * (1 << 24) + r.devfn * (1 << 16) + (r.off - o));
    q_data.push_back({d1, d0}); q_ctl.push_back(2'b01); q_newroot.push_back(-1);
    if (r.wr != 0 && (r.off % 8) == 0) begin
      q_data.push_back({32'h0, d2}); q_ctl.push_back(2'b00); q_newroot.push_back(-1);
      q_data.push_back({32'h0, dat}); q_ctl.push_back(2'b10);
    end else begin
      q_data.push_back({dat, d2}); q_ctl.push_back(2'b10);
    end
    if (r.wr != 0 && t0 && (r.off - o) == 'h18) q_newroot.push_back(int'(dat[7:0]));
    else                                          q_newroot.push_back(-1);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int idle_cnt;
    bit was_empty;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    tx_ready  = 1'b0;
    req_bus   = '0;
    req_devfn = '0;
    req_off   = '0;
    req_size  = '0;
    req_write = 1'b0;
    req_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 req_ready in reset", 64'(req_ready), 64'd1);
    chk("R1 tx_valid in reset", 64'(tx_valid), 64'd0);
    chk("R1 root_bus in reset", 64'(root_bus), 64'd0);
    rst_n = 1'b1;

    // directed: types, sizes, alignments (R4 R7 R8 R9 R10)
    add_req(0, 'h00, 'h000, 2, 0, 0);
    add_req(3, 'h08, 'h004, 2, 0, 0);
    add_req(5, 'h11, 'h001, 0, 1, 32'hDEADBEA5);
    add_req(5, 'h11, 'h003, 1, 1, 32'h1234ABCD);
    add_req(2, 'h00, 'h010, 2, 1, 32'hCAFEF00D);
    add_req(1, 'h20, 'h106, 1, 1, 32'h00005AA5);
    add_req(0, 'h00, 'h008, 0, 1, 32'h000000C3);
    // root bus tracking (R11) and its effect on type choice (R8)
    add_req(0, 'h00, 'h018, 2, 1, 32'h00000007);
    add_req(7, 'h00, 'h040, 2, 0, 0);
    add_req(0, 'h00, 'h040, 2, 0, 0);
    add_req(0, 'h00, 'h018, 2, 1, 32'h00000009);
    add_req(7, 'h00, 'h019, 0, 1, 32'h00000022);
    add_req(0, 'h00, 'h010, 2, 0, 0);
    for (int i = 0; i < 120; i++)
      add_req($urandom % 4, $urandom % 256, $urandom % 4096, $urandom % 4,
              $urandom % 2, $urandom);

    idle_cnt = 0;
    while (idle_cnt < 4) begin
      @(negedge clk);
      chk("R2 req_ready", 64'(req_ready), 64'(q_data.size() == 0));
      chk("R2 R3 tx_valid", 64'(tx_valid), 64'(q_data.size() != 0));
      chk("R11 root_bus", 64'(root_bus), 64'(model_root));
      if (q_data.size() != 0 && tx_valid) begin
        if (q_ctl[0] == 2'b01) begin
          chk("R5 R8 header dword0", 64'(tx_data[31:0]), 64'(q_data[0][31:0]));
          chk("R4 R6 header dword1", 64'(tx_data[63:32]), 64'(q_data[0][63:32]));
        end else begin
          chk("R7 R9 R10 beat", tx_data, q_data[0]);
        end
        chk("R10 tx_ctl", 64'(tx_ctl), 64'(q_ctl[0]));
      end

      lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tx_ready = lfsr[0] | lfsr[3];
      if (pend.size() != 0) begin
        req_valid = 1'b1;
        req_bus   = 8'(pend[0].bus);
        req_devfn = 8'(pend[0].devfn);
        req_off   = 12'(pend[0].off);
        req_size  = 2'(pend[0].size);
        req_write = (pend[0].wr != 0);
        req_wdata = pend[0].wd;
      end else begin
        req_valid = 1'b0;
      end

      was_empty = (q_data.size() == 0);
      if (!was_empty && tx_ready) begin
        if (q_newroot[0] >= 0) model_root = q_newroot[0];
        void'(q_data.pop_front());
        void'(q_ctl.pop_front());
        void'(q_newroot.pop_front());
      end
      if (was_empty && req_valid) begin
        build(pend[0]);
        void'(pend.pop_front());
      end
      if (pend.size() == 0 && q_data.size() == 0) idle_cnt++;
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule